// File: doc/BRIEF.md
# Oversampling Asynchronous Character Receiver

This block receives asynchronous serial characters on a single NRZ line. Its clock runs at sixteen times the bit rate, so every clock edge is one sample. A falling edge on the synchronised line starts a character. Each bit cell then spans sixteen samples, and its value is the majority of the three samples nearest the cell centre. Start bits whose centre vote comes out high are treated as noise and thrown away.

Data bits arrive least significant first. An optional even or odd parity bit may follow the data, and one stop bit ends the character. Each finished character is placed in a one-entry output register together with a status byte, and a valid/ready pair hands it on.

The receiver also compares each character against a programmable termination character. It runs an idle timer that fires once when no new character has arrived for a programmed number of clocks. Parity, framing, termination and time-out events set sticky flags. The flags are cleared by writing ones, and unmasked flags drive a single interrupt request.

Top module: `osr_async_rx`

## Requirements
- R1: Each bit cell is 16 clocks long. Sample 0 is the first clock on which the synchronised line is seen low after being high. The bit value is the majority of samples 7, 8 and 9 of its cell. Data bits come least significant first and appear on `out_data`.
- R2: A start bit whose majority at samples 7, 8 and 9 is high is discarded without producing a character. A low pulse of 8 samples or fewer is therefore rejected.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` 0 the data and parity ones must total an even count; with 1 they must total an odd count. A mismatch sets flag bit 0.
- R4: Status bit 0 carries the parity error only while `cfg_stat_fwd` is 1; otherwise it reads 0, while flag bit 0 is still set.
- R5: A stop bit whose majority is 0 sets status bit 1 and flag bit 1.
- R6: With `cfg_term_en` 1, a character equal to `cfg_term_char` sets status bit 2 and flag bit 2. With the enable at 0, no such match is reported.
- R7: With `cfg_to_en` 1, flag bit 3 sets exactly `cfg_to_limit`+1 clocks after the edge on which `out_valid` rose for a character. It fires once per character. A new start bit cancels the pending time-out, and the next character restarts it.
- R8: `out_valid` and `out_data`/`out_status` hold until `out_ready` is 1. A character that completes while the register is held full is dropped.
- R9: Flags are sticky. An `irq_clr` bit of 1 clears its flag on the next edge, but a flag event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when a flag is set whose `irq_mask` bit is 0. A mask bit of 1 suppresses that flag.
- R11: After reset, `out_valid`, `irq_flags` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stat_fwd | input | 1 | Forward parity error into status bit 0 |
| cfg_term_en | input | 1 | Enable termination compare |
| cfg_term_char | input | 8 | Termination character |
| cfg_to_en | input | 1 | Enable idle time-out |
| cfg_to_limit | input | 16 | Idle time-out in clocks |
| irq_mask | input | 4 | 1 = flag masked |
| irq_clr | input | 4 | Write-one-to-clear pulses |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Consumer takes character |
| out_data | output | 8 | Received character |
| out_status | output | 8 | bit0 parity, bit1 framing, bit2 termination match |
| irq_flags | output | 4 | bit0 parity, bit1 framing, bit2 termination, bit3 time-out |
| irq | output | 1 | Interrupt request |

## Verification
The time-out flag and its write-one clear can land on the same edge. The bench provokes this by locating the edge where `out_valid` rises and counting exactly `cfg_to_limit` further edges. It then holds the clear bit across the following edge, the one on which the time-out sets. The flag must read 1 afterwards, and a lone clear one cycle later must take it to 0. A second collision arises when a start bit begins during a pending time-out. That case is judged by the flag staying low at the second character and firing only relative to it.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int FLG_PAR  = 0;
  localparam int FLG_FRM  = 1;
  localparam int FLG_TERM = 2;
  localparam int FLG_TMO  = 3;
  localparam int NUM_FLG  = 4;

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // data_odd: xor of data bits; odd_mode: expected odd total
  function automatic logic parity_bad(input logic data_odd, input logic pbit,
                                      input logic odd_mode);
    return (data_odd ^ pbit) != odd_mode;
  endfunction

endpackage

// File: rtl/osr_rx_sampler.sv
module osr_rx_sampler
  import osr_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 start_seen,
  output logic                 char_done,
  output logic [DATA_BITS-1:0] char_data,
  output logic                 par_err,
  output logic                 frm_err
);

  localparam int CW = $clog2(OSR);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] C_A    = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_B    = CW'(OSR / 2);
  localparam logic [CW-1:0] C_C    = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_BITS - 1);

  rx_state_e            state;
  logic                 sync1, sync2, prev;
  logic [CW-1:0]        cnt;
  logic                 s_a, s_b, pbit;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 center, wrap, vote;

  assign vote       = vote3(s_a, s_b, sync2);
  assign center     = (state != ST_IDLE) && (cnt == C_C);
  assign wrap       = (cnt == C_LAST);
  assign start_seen = (state == ST_IDLE) && prev && !sync2;
  assign char_done  = (state == ST_STOP) && center;
  assign char_data  = shreg;
  assign frm_err    = !vote;
  assign par_err    = par_en && parity_bad(^shreg, pbit, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      prev    <= 1'b1;
      state   <= ST_IDLE;
      cnt     <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      pbit    <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      prev  <= sync2;
      if (state == ST_IDLE) begin
        if (start_seen) begin
          state <= ST_START;
          cnt   <= CW'(1);
        end
      end else begin
        cnt <= wrap ? '0 : cnt + 1'b1;
        if (cnt == C_A) s_a <= sync2;
        if (cnt == C_B) s_b <= sync2;
        case (state)
          ST_START: begin
            if (center && vote) state <= ST_IDLE;
            else if (wrap) begin
              state   <= ST_DATA;
              bit_idx <= '0;
            end
          end
          ST_DATA: begin
            if (center) shreg <= {vote, shreg[DATA_BITS-1:1]};
            if (wrap) begin
              if (bit_idx == B_LAST) state <= par_en ? ST_PAR : ST_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_PAR: begin
            if (center) pbit <= vote;
            if (wrap) state <= ST_STOP;
          end
          ST_STOP: begin
            if (center) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: an accepted edge always enters the start-bit check
  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (state == ST_START));

  // R1: a character completes only at a stop-bit centre
  a_r1_done_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> (state == ST_IDLE));

endmodule

// File: rtl/osr_rx_events.sv
module osr_rx_events #(
  parameter int DATA_BITS = 8,
  parameter int TO_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_done,
  input  logic [DATA_BITS-1:0] char_data,
  input  logic                 start_seen,
  input  logic                 term_en,
  input  logic [DATA_BITS-1:0] term_char,
  input  logic                 to_en,
  input  logic [TO_W-1:0]      to_limit,
  output logic                 term_hit,
  output logic                 to_pulse
);

  logic [TO_W-1:0] tcnt;
  logic            armed;

  assign term_hit = term_en && (char_data == term_char);
  assign to_pulse = armed && to_en && (tcnt == to_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      armed <= 1'b0;
    end else if (char_done) begin
      tcnt  <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (start_seen || to_pulse) armed <= 1'b0;
      else if (tcnt != '1) tcnt <= tcnt + 1'b1;
    end
  end

  // R7: the time-out fires once per armed interval
  a_r7_once: assert property (@(posedge clk) disable iff (!rst_n)
    to_pulse |=> !to_pulse);

  // R7: a start bit disarms the timer
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !char_done) |=> !to_pulse);

endmodule

// File: rtl/osr_rx_irq.sv
module osr_rx_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign irq = |(flags & ~mask);

  // R9: an event sets its flag even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));

  // R9: uncleared flags stay set
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~clr)) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  // R10: a full mask silences the request
  a_r10_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);

endmodule

// File: rtl/osr_async_rx.sv
module osr_async_rx
  import osr_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16,
  parameter int TO_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_stat_fwd,
  input  logic                 cfg_term_en,
  input  logic [DATA_BITS-1:0] cfg_term_char,
  input  logic                 cfg_to_en,
  input  logic [TO_W-1:0]      cfg_to_limit,
  input  logic [3:0]           irq_mask,
  input  logic [3:0]           irq_clr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_BITS-1:0] out_data,
  output logic [7:0]           out_status,
  output logic [3:0]           irq_flags,
  output logic                 irq
);

  logic                 start_seen, char_done, par_err, frm_err;
  logic                 term_hit, to_pulse, load;
  logic [DATA_BITS-1:0] char_data;
  logic [NUM_FLG-1:0]   flag_set;
  logic [7:0]           status_next;

  osr_rx_sampler #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .par_en     (cfg_par_en),
    .par_odd    (cfg_par_odd),
    .start_seen (start_seen),
    .char_done  (char_done),
    .char_data  (char_data),
    .par_err    (par_err),
    .frm_err    (frm_err)
  );

  osr_rx_events #(.DATA_BITS(DATA_BITS), .TO_W(TO_W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (char_done),
    .char_data  (char_data),
    .start_seen (start_seen),
    .term_en    (cfg_term_en),
    .term_char  (cfg_term_char),
    .to_en      (cfg_to_en),
    .to_limit   (cfg_to_limit),
    .term_hit   (term_hit),
    .to_pulse   (to_pulse)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_PAR]  = char_done && par_err;
    flag_set[FLG_FRM]  = char_done && frm_err;
    flag_set[FLG_TERM] = char_done && term_hit;
    flag_set[FLG_TMO]  = to_pulse;
    status_next        = '0;
    status_next[0]     = par_err && cfg_stat_fwd;
    status_next[1]     = frm_err;
    status_next[2]     = term_hit;
  end

  osr_rx_irq #(.N(NUM_FLG)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (irq_clr),
    .mask  (irq_mask),
    .flags (irq_flags),
    .irq   (irq)
  );

  assign load = char_done && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_status <= '0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_data   <= char_data;
      out_status <= status_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8: a held character stays put until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_status)));

endmodule

// File: tb/sim_osr_async_rx.sv
module sim_osr_async_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stat_fwd = 1'b0;
  logic       cfg_term_en = 1'b0, cfg_to_en = 1'b0;
  logic [7:0] cfg_term_char = 8'h0D;
  logic [15:0] cfg_to_limit = 16'd100;
  logic [3:0] irq_mask = 4'h0, irq_clr = 4'h0;
  logic       out_ready = 1'b0;
  logic       out_valid, irq;
  logic [7:0] out_data, out_status;
  logic [3:0] irq_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  localparam int L = 100;

  always #10 clk = ~clk;

  osr_async_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stat_fwd(cfg_stat_fwd),
    .cfg_term_en(cfg_term_en), .cfg_term_char(cfg_term_char),
    .cfg_to_en(cfg_to_en), .cfg_to_limit(cfg_to_limit),
    .irq_mask(irq_mask), .irq_clr(irq_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_status(out_status), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input bit wp, input logic pb, input logic sv);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    if (wp) hold(pb, 16);
    hold(sv, 16);
    if (!sv) hold(1'b1, 16);
    hold(1'b1, 4);
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(d[i]);
    return (c % 2) == 1;
  endfunction

  task automatic read_chk(input string tag, input logic [7:0] ed, input logic [7:0] es);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " data"}, int'(out_data), int'(ed));
    chk({tag, " status"}, int'(out_status), int'(es));
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    chk({tag, " taken"}, int'(out_valid), 0);
  endtask

  task automatic clr_all();
    irq_clr = 4'hF;
    @(posedge clk); #1;
    irq_clr = 4'h0;
  endtask

  task automatic wait_valid();
    do begin
      @(posedge clk); #1;
    end while (!out_valid);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", int'(out_valid), 0);
    chk("R11 reset flags", int'(irq_flags), 0);
    chk("R11 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    hold(1'b1, 8);

    // R1: every byte value, no parity
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 0, 1'b0, 1'b1);
      read_chk("R1 sweep", 8'(v), 8'h00);
    end
    chk("R1 no flags", int'(irq_flags), 0);

    // R2: 8-sample low pulse is noise
    hold(1'b0, 8);
    hold(1'b1, 40);
    chk("R2 glitch rejected", int'(out_valid), 0);
    send(8'hA5, 0, 1'b0, 1'b1);
    read_chk("R2 after glitch", 8'hA5, 8'h00);

    // R3 / R4: parity sweeps
    cfg_par_en = 1'b1;
    cfg_stat_fwd = 1'b1;
    for (int m = 0; m < 2; m++) begin
      cfg_par_odd = m[0];
      for (int v = 0; v < 256; v += 9) begin
        logic good;
        good = ones_odd(8'(v)) ^ m[0];
        clr_all();
        send(8'(v), 1, good, 1'b1);
        read_chk("R3 good parity", 8'(v), 8'h00);
        chk("R3 no parity flag", int'(irq_flags[0]), 0);
        send(8'(v), 1, ~good, 1'b1);
        read_chk("R3 R4 bad parity fwd", 8'(v), 8'h01);
        chk("R3 parity flag", int'(irq_flags[0]), 1);
      end
    end
    cfg_stat_fwd = 1'b0;
    cfg_par_odd = 1'b0;
    clr_all();
    send(8'h03, 1, 1'b1, 1'b1);
    read_chk("R4 not forwarded", 8'h03, 8'h00);
    chk("R4 flag still set", int'(irq_flags[0]), 1);
    cfg_par_en = 1'b0;

    // R5: framing
    clr_all();
    send(8'h5A, 0, 1'b0, 1'b0);
    read_chk("R5 framing status", 8'h5A, 8'h02);
    chk("R5 framing flag", int'(irq_flags), 4'h2);

    // R10: masking
    irq_mask = 4'hF;
    #1 chk("R10 all masked", int'(irq), 0);
    irq_mask = 4'hD;
    #1 chk("R10 unmasked framing", int'(irq), 1);
    irq_mask = 4'h2;
    #1 chk("R10 framing masked", int'(irq), 0);
    irq_mask = 4'h0;
    clr_all();
    chk("R9 clear all", int'(irq_flags), 0);

    // R6: termination character
    cfg_term_en = 1'b1;
    send(8'h0D, 0, 1'b0, 1'b1);
    read_chk("R6 match", 8'h0D, 8'h04);
    chk("R6 match flag", int'(irq_flags[2]), 1);
    clr_all();
    send(8'h0C, 0, 1'b0, 1'b1);
    read_chk("R6 other char", 8'h0C, 8'h00);
    chk("R6 no flag", int'(irq_flags[2]), 0);
    cfg_term_en = 1'b0;
    send(8'h0D, 0, 1'b0, 1'b1);
    read_chk("R6 disabled", 8'h0D, 8'h00);
    chk("R6 disabled flag", int'(irq_flags[2]), 0);

    // R7: exact time-out position
    cfg_to_en = 1'b1;
    clr_all();
    fork
      send(8'h41, 0, 1'b0, 1'b1);
      begin
        wait_valid();
        repeat (L - 1) @(posedge clk);
        #1 chk("R7 early", int'(irq_flags[3]), 0);
        @(posedge clk);
        #1 chk("R7 at limit", int'(irq_flags[3]), 0);
        @(posedge clk);
        #1 chk("R7 fired", int'(irq_flags[3]), 1);
      end
    join
    read_chk("R7 data", 8'h41, 8'h00);

    // R9: set and clear on the same edge
    clr_all();
    fork
      send(8'h42, 0, 1'b0, 1'b1);
      begin
        wait_valid();
        repeat (L) @(posedge clk);
        #1 irq_clr = 4'h8;
        @(posedge clk);
        #1 irq_clr = 4'h0;
        chk("R9 set wins", int'(irq_flags[3]), 1);
        irq_clr = 4'h8;
        @(posedge clk);
        #1 irq_clr = 4'h0;
        chk("R9 clear", int'(irq_flags[3]), 0);
        repeat (30) @(posedge clk);
        #1 chk("R7 fires once", int'(irq_flags[3]), 0);
      end
    join
    read_chk("R9 data", 8'h42, 8'h00);

    // R7: back-to-back characters cancel the first time-out
    clr_all();
    out_ready = 1'b1;
    fork
      begin
        send(8'h61, 0, 1'b0, 1'b1);
        send(8'h62, 0, 1'b0, 1'b1);
      end
      begin
        wait_valid();
        chk("R7 first char", int'(out_data), 8'h61);
        wait_valid();
        chk("R7 second char", int'(out_data), 8'h62);
        chk("R7 cancelled", int'(irq_flags[3]), 0);
        repeat (L) @(posedge clk);
        #1 chk("R7 restart not yet", int'(irq_flags[3]), 0);
        @(posedge clk);
        #1 chk("R7 restart fired", int'(irq_flags[3]), 1);
      end
    join
    out_ready = 1'b0;
    cfg_to_en = 1'b0;
    @(posedge clk); #1;

    // R8: second character dropped while held
    send(8'h11, 0, 1'b0, 1'b1);
    send(8'h22, 0, 1'b0, 1'b1);
    read_chk("R8 first kept", 8'h11, 8'h00);
    hold(1'b1, 20);
    chk("R8 second dropped", int'(out_valid), 0);

    finish_run();
  end

endmodule